// File: doc/BRIEF.md
# Padded-Lane Partitioned Adder

This block adds two 32-bit packed words as one, two or four independent lanes, chosen by a 2-bit element-width select. The lanes do not fill their slots. Each slot starts on a power-of-two boundary and holds one lane at its low end, and the rest of the slot is padding:

- In the wide mode the single lane is 11 bits wide.
- In the half mode both lanes are 11 bits wide.
- In the quarter mode all four lanes are 5 bits wide.

Each slot is aligned, so every lane maps straight onto wires. Wider logic can then treat each lane as a scalar of that width.

The carry chain is cut in only three ways, one for each supported mode. It is never cut at every breakpoint that some mode might need. Some bit positions carry no active lane in any mode. These positions form a static blanking mask, and the design builds no adder cell for them.

The block is purely combinational. The sum and the per-lane carries follow the operands and the select with no latency. No handshake is involved.

Top module: `simd_padlane_adder`

## Requirements
- R1: With `ew_sel` = 0, `{lane_cout[0], sum_out[10:0]}` equals `in_a[10:0] + in_b[10:0]`.
- R2: With `ew_sel` = 1, the lanes sit at bits 10:0 and 26:16. For each lane k, `{lane_cout[k], lane sum}` equals the 12-bit sum of the two operand lanes.
- R3: With `ew_sel` = 2, four 5-bit lanes sit at bits 4:0, 12:8, 20:16 and 28:24. For each lane k, `{lane_cout[k], lane sum}` equals the 6-bit sum of the two operand lanes.
- R4: `ew_sel` = 3 gives exactly the same outputs as `ew_sel` = 0.
- R5: Every `sum_out` bit outside the active lanes of the current mode is 0. Bits 15:13 and 31:29 are 0 in every mode.
- R6: Operand bits outside the active lanes have no effect on any output. In particular, no carry crosses from padding into a lane.
- R7: Each lane wraps modulo 2 to the power of its width. An all-ones lane plus one gives a lane sum of zero with the lane carry set.
- R8: `lane_cout` bits for lanes that do not exist in the current mode are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_a | input | 32 | First packed operand |
| in_b | input | 32 | Second packed operand |
| ew_sel | input | 2 | Element width: 0 wide, 1 half, 2 quarter, 3 same as 0 |
| sum_out | output | 32 | Packed lane sums, with padding forced to zero |
| lane_cout | output | 4 | Carry out of each lane, bit k for lane k |

## Verification
Whenever the inputs are known, the assertions check the following:

- The blanked bits and the padding bits of the current mode are zero.
- The carry bits of lanes that do not exist are zero.
- Lane 0 matches a plain add in the wide and quarter modes.
- The alias code behaves like the wide mode.

Only the bench scenarios can show that upper lanes stay isolated, because this needs two runs compared with each other. In those runs the padding is flipped between otherwise identical operands. The same holds for exact wrap at each lane width, and for agreement with a per-lane reference across many random operands.

// File: rtl/simd_pad_pkg.sv
package simd_pad_pkg;

  localparam int WORD_W      = 32;
  localparam int LANES_MAX   = 4;
  localparam int MODES       = 3;
  localparam int WIDE_LANE_W = 11;
  localparam int SMALL_LANE_W = 5;

  typedef enum logic [1:0] {
    EW_WIDE    = 2'd0,
    EW_HALF    = 2'd1,
    EW_QUARTER = 2'd2,
    EW_ALIAS   = 2'd3
  } ew_sel_e;

  function automatic int lanes_of(input int m);
    return 1 << m;
  endfunction

  function automatic int slot_of(input int m);
    return WORD_W / lanes_of(m);
  endfunction

  function automatic int lane_w_of(input int m);
    return (m == MODES - 1) ? SMALL_LANE_W : WIDE_LANE_W;
  endfunction

  function automatic int lane_msb(input int m, input int l);
    return l * slot_of(m) + lane_w_of(m) - 1;
  endfunction

  function automatic logic [WORD_W-1:0] active_mask(input int m);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int l = 0; l < lanes_of(m); l++)
      for (int k = 0; k < lane_w_of(m); k++)
        r[l * slot_of(m) + k] = 1'b1;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] start_mask(input int m);
    logic [WORD_W-1:0] r;
    r = '0;
    for (int l = 0; l < lanes_of(m); l++)
      r[l * slot_of(m)] = 1'b1;
    return r;
  endfunction

  function automatic logic [WORD_W-1:0] used_mask();
    logic [WORD_W-1:0] r;
    r = '0;
    for (int m = 0; m < MODES; m++)
      r = r | active_mask(m);
    return r;
  endfunction

endpackage

// File: rtl/simd_mode_decode.sv
module simd_mode_decode
  import simd_pad_pkg::*;
(
  input  logic [1:0]       ew_sel,
  output logic [MODES-1:0] mode_oh
);
  ew_sel_e sel_e;

  always_comb begin
    sel_e   = ew_sel_e'(ew_sel);
    mode_oh = '0;
    unique case (sel_e)
      EW_HALF:    mode_oh[1] = 1'b1;
      EW_QUARTER: mode_oh[2] = 1'b1;
      default:    mode_oh[0] = 1'b1;
    endcase
  end
endmodule

// File: rtl/simd_break_select.sv
module simd_break_select
  import simd_pad_pkg::*;
(
  input  logic [MODES-1:0]  mode_oh,
  output logic [WORD_W-1:0] act_mask,
  output logic [WORD_W-1:0] kill_mask
);
  logic [MODES-1:0][WORD_W-1:0] act_terms;
  logic [MODES-1:0][WORD_W-1:0] kill_terms;

  for (genvar m = 0; m < MODES; m++) begin : g_mode
    localparam logic [WORD_W-1:0] ACT  = active_mask(m);
    localparam logic [WORD_W-1:0] KILL = start_mask(m);
    assign act_terms[m]  = mode_oh[m] ? ACT  : '0;
    assign kill_terms[m] = mode_oh[m] ? KILL : '0;
  end

  always_comb begin
    act_mask  = '0;
    kill_mask = '0;
    for (int m = 0; m < MODES; m++) begin
      act_mask  = act_mask  | act_terms[m];
      kill_mask = kill_mask | kill_terms[m];
    end
  end
endmodule

// File: rtl/simd_seg_adder.sv
module simd_seg_adder
  import simd_pad_pkg::*;
(
  input  logic [WORD_W-1:0]    a,
  input  logic [WORD_W-1:0]    b,
  input  logic [WORD_W-1:0]    kill_mask,
  input  logic [MODES-1:0]     mode_oh,
  output logic [WORD_W-1:0]    sum_raw,
  output logic [LANES_MAX-1:0] lane_cy
);
  localparam logic [WORD_W-1:0] USED = used_mask();

  logic [WORD_W-1:0] cy;
  logic [WORD_W-1:0] cin;

  for (genvar i = 0; i < WORD_W; i++) begin : g_bit
    if (USED[i]) begin : g_cell
      if (i == 0) begin : g_lsb
        assign cin[i] = 1'b0;
      end else begin : g_link
        assign cin[i] = kill_mask[i] ? 1'b0 : cy[i-1];
      end
      assign sum_raw[i] = a[i] ^ b[i] ^ cin[i];
      assign cy[i]      = (a[i] & b[i]) | (cin[i] & (a[i] ^ b[i]));
    end else begin : g_blank
      assign cin[i]     = 1'b0;
      assign sum_raw[i] = 1'b0;
      assign cy[i]      = 1'b0;
    end
  end

  logic [LANES_MAX-1:0][MODES-1:0] cy_terms;

  for (genvar l = 0; l < LANES_MAX; l++) begin : g_lane
    for (genvar m = 0; m < MODES; m++) begin : g_md
      if (l < lanes_of(m)) begin : g_on
        assign cy_terms[l][m] = mode_oh[m] & cy[lane_msb(m, l)];
      end else begin : g_off
        assign cy_terms[l][m] = 1'b0;
      end
    end
    assign lane_cy[l] = |cy_terms[l];
  end

  logic unused_seg_bits;
  assign unused_seg_bits = &{1'b0, cy[WORD_W-1], cin, a & ~USED, b & ~USED, kill_mask};
endmodule

// File: rtl/simd_padlane_adder.sv
module simd_padlane_adder
  import simd_pad_pkg::*;
(
  input  logic [31:0] in_a,
  input  logic [31:0] in_b,
  input  logic [1:0]  ew_sel,
  output logic [31:0] sum_out,
  output logic [3:0]  lane_cout
);
  logic [MODES-1:0]  mode_oh;
  logic [WORD_W-1:0] act_mask;
  logic [WORD_W-1:0] kill_mask;
  logic [WORD_W-1:0] sum_raw;

  simd_mode_decode u_dec (
    .ew_sel  (ew_sel),
    .mode_oh (mode_oh)
  );

  simd_break_select u_brk (
    .mode_oh   (mode_oh),
    .act_mask  (act_mask),
    .kill_mask (kill_mask)
  );

  simd_seg_adder u_add (
    .a         (in_a),
    .b         (in_b),
    .kill_mask (kill_mask),
    .mode_oh   (mode_oh),
    .sum_raw   (sum_raw),
    .lane_cy   (lane_cout)
  );

  assign sum_out = sum_raw & act_mask;
endmodule

// File: rtl/simd_padlane_adder_chk.sv
module simd_padlane_adder_chk (
  input logic [31:0] in_a,
  input logic [31:0] in_b,
  input logic [1:0]  ew_sel,
  input logic [31:0] sum_out,
  input logic [3:0]  lane_cout
);
  logic known;
  logic [11:0] wide0;
  logic [5:0]  small0;

  always_comb begin
    known  = !$isunknown({in_a, in_b, ew_sel, sum_out, lane_cout});
    wide0  = {1'b0, in_a[10:0]} + {1'b0, in_b[10:0]};
    small0 = {1'b0, in_a[4:0]} + {1'b0, in_b[4:0]};
    if (known) begin
      // R5: blanked positions never carry data
      p_blank_zero_r5: assert ((sum_out & 32'hE000_E000) == 32'h0)
        else $error("blanked bits set");
      // R5: padding of the current mode is zero
      if (ew_sel == 2'd1)
        p_pad_half_r5: assert ((sum_out & ~32'h07FF_07FF) == 32'h0) else $error("half padding");
      else if (ew_sel == 2'd2)
        p_pad_qtr_r5: assert ((sum_out & ~32'h1F1F_1F1F) == 32'h0) else $error("quarter padding");
      else
        p_pad_wide_r5: assert ((sum_out & ~32'h0000_07FF) == 32'h0) else $error("wide padding");
      // R8: carries of absent lanes are zero
      if (ew_sel == 2'd1)
        p_cy_half_r8: assert (lane_cout[3:2] == 2'b00) else $error("half carry");
      else if (ew_sel != 2'd2)
        p_cy_wide_r8: assert (lane_cout[3:1] == 3'b000) else $error("wide carry");
      // R1 / R4: wide lane and alias code match a plain 11-bit add
      if (ew_sel == 2'd0 || ew_sel == 2'd3)
        p_wide_sum_r1: assert ({lane_cout[0], sum_out[10:0]} == wide0) else $error("wide sum");
      // R3 / R6: quarter lane 0 ignores padding above bit 4
      if (ew_sel == 2'd2)
        p_qtr_lane0_r3: assert ({lane_cout[0], sum_out[4:0]} == small0) else $error("qtr lane0");
    end
  end
endmodule

bind simd_padlane_adder simd_padlane_adder_chk u_chk (
  .in_a      (in_a),
  .in_b      (in_b),
  .ew_sel    (ew_sel),
  .sum_out   (sum_out),
  .lane_cout (lane_cout)
);

// File: tb/simd_padlane_adder_bench.sv
module simd_padlane_adder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic [31:0] in_a, in_b, sum_out;
  logic [1:0]  ew_sel;
  logic [3:0]  lane_cout;

  simd_padlane_adder u_simd_padlane_adder (
    .in_a(in_a), .in_b(in_b), .ew_sel(ew_sel),
    .sum_out(sum_out), .lane_cout(lane_cout)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct packed {
    logic [1:0]  sel;
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] s;
    logic [3:0]  c;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VT [NV] = '{
    '{2'd0, 32'h0000_07FF, 32'h0000_0001, 32'h0000_0000, 4'h1}, // R1 R7
    '{2'd2, 32'h1F1F_1F1F, 32'h0101_0101, 32'h0000_0000, 4'hF}, // R3 R7
    '{2'd1, 32'hFFFF_FFFF, 32'h0000_0000, 32'h07FF_07FF, 4'h0}, // R2 R5
    '{2'd3, 32'h0000_0123, 32'h0000_0456, 32'h0000_0579, 4'h0}, // R4
    '{2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1E1E_1E1E, 4'hF}, // R3 R5
    '{2'd1, 32'h0400_0400, 32'h0400_0400, 32'h0000_0000, 4'h3}, // R2 R7
    '{2'd0, 32'hFFFF_F800, 32'hFFFF_F800, 32'h0000_0000, 4'h0}, // R6
    '{2'd2, 32'h0000_00E0, 32'h0000_00E0, 32'h0000_0000, 4'h0}  // R6
  };
  localparam string VTAG [NV] = '{"R1/R7", "R3/R7", "R2/R5", "R4",
                                  "R3/R5", "R2/R7", "R6", "R6"};

  // Per-lane reference, written from the requirements
  function automatic logic [35:0] ref_add(input logic [1:0] sel,
                                          input logic [31:0] a, input logic [31:0] b);
    int n, slot, w, base;
    logic [31:0] s, mask, la, lb, t;
    logic [3:0] c;
    n = (sel == 2'd1) ? 2 : (sel == 2'd2) ? 4 : 1;
    slot = 32 / n;
    w = (n == 4) ? 5 : 11;
    mask = (32'h1 << w) - 32'h1;
    s = '0; c = '0;
    for (int l = 0; l < n; l++) begin
      base = l * slot;
      la = (a >> base) & mask;
      lb = (b >> base) & mask;
      t  = la + lb;
      s  = s | ((t & mask) << base);
      c[l] = t[w];
    end
    return {c, s};
  endfunction

  function automatic logic [31:0] lane_mask(input logic [1:0] sel);
    return (sel == 2'd1) ? 32'h07FF_07FF : (sel == 2'd2) ? 32'h1F1F_1F1F : 32'h0000_07FF;
  endfunction

  task automatic apply(input logic [1:0] sel, input logic [31:0] a, input logic [31:0] b);
    @(posedge clk);
    ew_sel = sel; in_a = a; in_b = b;
    @(negedge clk);
  endtask

  task automatic check(input string tag, input logic [31:0] es, input logic [3:0] ec);
    checks++;
    if (sum_out !== es || lane_cout !== ec) begin
      fails++;
      $display("FAIL %s sel=%0d a=%h b=%h: got sum=%h cout=%h, expected sum=%h cout=%h",
               tag, ew_sel, in_a, in_b, sum_out, lane_cout, es, ec);
    end
  endtask

  initial begin
    ew_sel = 2'd0; in_a = '0; in_b = '0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R5 reset/zero", 32'h0, 4'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VT[i].sel, VT[i].a, VT[i].b);
      check(VTAG[i], VT[i].s, VT[i].c);
    end

    // Random per-mode comparison: R1 R2 R3 R4 R8
    for (int i = 0; i < 400; i++) begin
      logic [1:0] sel;
      logic [31:0] a, b;
      logic [35:0] r;
      sel = 2'(i % 4);
      a = $urandom; b = $urandom;
      r = ref_add(sel, a, b);
      apply(sel, a, b);
      check(sel == 2'd0 ? "R1" : sel == 2'd1 ? "R2" : sel == 2'd2 ? "R3" : "R4",
            r[31:0], r[35:32]);
      // R5 blanked bits always clear
      checks++;
      if ((sum_out & 32'hE000_E000) != 0) begin
        fails++;
        $display("FAIL R5 blank: got %h expected 0", sum_out & 32'hE000_E000);
      end
    end

    // R6: flipping padding leaves outputs unchanged
    for (int i = 0; i < 60; i++) begin
      logic [1:0] sel;
      logic [31:0] a, b, m;
      logic [31:0] s0;
      logic [3:0]  c0;
      sel = 2'(i % 3);
      m = lane_mask(sel);
      a = $urandom; b = $urandom;
      apply(sel, a & m, b & m);
      s0 = sum_out; c0 = lane_cout;
      apply(sel, a | ~m, b ^ ~m);
      check("R6", s0, c0);
    end

    // R8: absent-lane carries with all-ones operands
    apply(2'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R8", 32'h07FE_07FE, 4'h3);
    apply(2'd0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    check("R8", 32'h0000_07FE, 4'h1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule